// File: doc/BRIEF.md
# Control Register Access Checker

This block holds the supervisor control registers of a processor core and services a single move-to/move-from access port. Each access presents a 12-bit register code, a direction and write data. The block decides whether the code names a register that the configured processor class provides. If it does, a write stores the value, masked where the class requires it, and a read returns the stored value. If it does not, the block raises a one-cycle illegal-instruction exception and changes nothing.

The processor class is a static configuration input with six defined levels:

| Class | Meaning |
|---|---|
| 0 | Base class. It has no control-register move. |
| 1 | Adds the move, with the minimal register set. |
| 2, 3 | Add the cache control register and the master and interrupt stack pointers. |
| 4 | Adds the full address-translation register set. |
| 5 | Keeps the translation root and control registers. It drops the master and interrupt stack pointers, the status register and the transparent windows, and masks cache control differently. |

Classes 6 and 7 are reserved and behave like class 0.

The instruction decoder asserts `req_i` for one cycle per access. It takes the result, and the exception pulse, one clock later.

Top module: `crchk_top`

## Requirements
- R1: When `cpu_class_i` is 0, 6 or 7, every access raises `exc_o` one cycle later.
- R2: Codes 0x000 and 0x001 (source and destination function codes), 0x800 (user stack pointer) and 0x801 (vector base) are legal on classes 1 to 5. The two function-code registers store only bits [2:0] of the written value, and the upper bits read as zero.
- R3: Code 0x002 (cache control) is legal on classes 2 to 5 and illegal on class 1.
- R4: A write to code 0x002 stores the value masked as follows:

  | Class | Stored value |
  |---|---|
  | 2, 3 | Full 32-bit value, unmasked |
  | 4 | Value AND 0x80008000 |
  | 5 | Value AND 0xF8E0E000 |

- R5: Codes 0x003 (translation control), 0x806 (user root) and 0x807 (supervisor root) are legal only on classes 4 and 5.
- R6: Codes 0x004 to 0x007 (two instruction and two data transparent windows) and 0x805 (translation status) are legal only on class 4.
- R7: Codes 0x803 (master stack) and 0x804 (interrupt stack) are legal only on classes 2, 3 and 4.
- R8: Code 0x802 (cache address) is unimplemented and always raises `exc_o`, as does every code not listed in R2 to R7.
- R9: A rejected access returns `rdata_o` = 0 and modifies no register.
- R10: `rdata_o` and `exc_o` update on the clock edge that samples `req_i` high. `exc_o` is high for exactly that one cycle. While `req_i` is low, `exc_o` stays low and `rdata_o` holds its value.
- R11: After `rst_ni` is asserted, every register reads zero, and `rdata_o` and `exc_o` are zero.
- R12: A legal write raises no exception and returns `rdata_o` = 0. A legal read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_class_i | input | 3 | Configured processor class, 0 to 5 |
| req_i | input | 1 | Access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| code_i | input | 12 | Control register code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| exc_o | output | 1 | Registered illegal-instruction pulse |

## Verification
A wrong legality entry shows up one cycle after the offending access. Either an exception appears where a value was expected, or a value comes back with no exception. A wrong mask or a write leaking into a neighbouring register stays hidden until that register is read back. For this reason the stimulus reads every written register after the write, and again after rejected accesses and after a class change. A stuck exception or a drifting read bus shows on the first idle cycle after an access.

// File: rtl/crchk_pkg.sv
package crchk_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned CLASS_W = 3;
  localparam int unsigned NREG    = 15;
  localparam int unsigned IDX_W   = $clog2(NREG + 1);

  typedef enum logic [IDX_W-1:0] {
    IX_SRC_FC, IX_DST_FC, IX_CACHE, IX_XLAT, IX_IWIN0, IX_IWIN1,
    IX_DWIN0, IX_DWIN1, IX_USER_SP, IX_VEC, IX_MAST_SP, IX_INT_SP,
    IX_XSTAT, IX_UROOT, IX_SROOT, IX_NONE
  } cr_idx_e;

  localparam logic [DATA_W-1:0] FC_MASK      = 32'h0000_0007;
  localparam logic [DATA_W-1:0] CACHE_MASK_4 = 32'h8000_8000;
  localparam logic [DATA_W-1:0] CACHE_MASK_5 = 32'hF8E0_E000;
endpackage

// File: rtl/crchk_decode.sv
module crchk_decode
  import crchk_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output cr_idx_e           idx_o
);
  always_comb begin
    unique case (code_i)
      12'h000: idx_o = IX_SRC_FC;
      12'h001: idx_o = IX_DST_FC;
      12'h002: idx_o = IX_CACHE;
      12'h003: idx_o = IX_XLAT;
      12'h004: idx_o = IX_IWIN0;
      12'h005: idx_o = IX_IWIN1;
      12'h006: idx_o = IX_DWIN0;
      12'h007: idx_o = IX_DWIN1;
      12'h800: idx_o = IX_USER_SP;
      12'h801: idx_o = IX_VEC;
      12'h803: idx_o = IX_MAST_SP;
      12'h804: idx_o = IX_INT_SP;
      12'h805: idx_o = IX_XSTAT;
      12'h806: idx_o = IX_UROOT;
      12'h807: idx_o = IX_SROOT;
      default: idx_o = IX_NONE;  // 0x802 unimplemented, rest unknown
    endcase
  end
endmodule

// File: rtl/crchk_legal.sv
module crchk_legal
  import crchk_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  input  cr_idx_e            idx_i,
  output logic               ok_o
);
  logic has_move, c23, c4, c5;
  always_comb begin
    has_move = (cls_i >= 3'd1) && (cls_i <= 3'd5);
    c23      = (cls_i == 3'd2) || (cls_i == 3'd3);
    c4       = (cls_i == 3'd4);
    c5       = (cls_i == 3'd5);
    unique case (idx_i)
      IX_SRC_FC, IX_DST_FC, IX_USER_SP, IX_VEC: ok_o = has_move;
      IX_CACHE:                                 ok_o = c23 | c4 | c5;
      IX_XLAT, IX_UROOT, IX_SROOT:              ok_o = c4 | c5;
      IX_IWIN0, IX_IWIN1, IX_DWIN0, IX_DWIN1,
      IX_XSTAT:                                 ok_o = c4;
      IX_MAST_SP, IX_INT_SP:                    ok_o = c23 | c4;
      default:                                  ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crchk_mask.sv
module crchk_mask
  import crchk_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  input  cr_idx_e            idx_i,
  output logic [DATA_W-1:0]  mask_o
);
  always_comb begin
    mask_o = '1;
    if (idx_i == IX_SRC_FC || idx_i == IX_DST_FC) begin
      mask_o = FC_MASK;
    end else if (idx_i == IX_CACHE) begin
      if (cls_i == 3'd4)      mask_o = CACHE_MASK_4;
      else if (cls_i == 3'd5) mask_o = CACHE_MASK_5;
    end
  end
endmodule

// File: rtl/crchk_top.sv
module crchk_top
  import crchk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CLASS_W-1:0] cpu_class_i,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               exc_o
);
  cr_idx_e           idx;
  logic              ok;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              exc_q;

  crchk_decode u_dec  (.code_i(code_i), .idx_o(idx));
  crchk_legal  u_legal(.cls_i(cpu_class_i), .idx_i(idx), .ok_o(ok));
  crchk_mask   u_mask (.cls_i(cpu_class_i), .idx_i(idx), .mask_o(mask));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (req_i && wr_i && ok && (idx == cr_idx_e'(g)))
        regs_q[g] <= wdata_i & mask;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == cr_idx_e'(i)) rd_mux = regs_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      exc_q <= req_i && !ok;
      if (req_i) rdata_q <= (ok && !wr_i) ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign exc_o   = exc_q;
endmodule

// File: rtl/crchk_checker.sv
module crchk_checker
  import crchk_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CLASS_W-1:0] cpu_class_i,
  input logic               req_i,
  input logic               wr_i,
  input logic [CODE_W-1:0]  code_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               exc_o
);
  logic no_move, win_code;
  assign no_move  = (cpu_class_i == 3'd0) || (cpu_class_i > 3'd5);
  assign win_code = (code_i >= 12'h004 && code_i <= 12'h007) || code_i == 12'h805;

  assert_no_move_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && no_move |=> exc_o);
  assert_user_sp_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !no_move && code_i == 12'h800 |=> !exc_o);
  assert_win_only_c4_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && win_code && cpu_class_i != 3'd4 |=> exc_o);
  assert_unimpl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && code_i == 12'h802 |=> exc_o);
  assert_exc_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> rdata_o == '0);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !exc_o && $stable(rdata_o));
  assert_write_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && wr_i |=> rdata_o == '0);
endmodule

bind crchk_top crchk_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_class_i(cpu_class_i), .req_i(req_i),
  .wr_i(wr_i), .code_i(code_i), .rdata_o(rdata_o), .exc_o(exc_o)
);

// File: tb/tb_crchk_top.sv
module tb_crchk_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cpu_class_i = 3'd1;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] code_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        exc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  crchk_top dut (.*);

  typedef struct packed {
    logic [2:0]  cls;
    logic        wr;
    logic [11:0] code;
    logic [31:0] wd;
    logic        exc;
    logic [31:0] rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b1, 12'h801, 32'h0000_1000, 1'b0, 32'h0, 4'd12},  // R12 write vector base
    '{3'd1, 1'b0, 12'h801, 32'h0,         1'b0, 32'h0000_1000, 4'd2},  // R2
    '{3'd1, 1'b0, 12'h002, 32'h0,         1'b1, 32'h0, 4'd3},  // R3 cache on class 1
    '{3'd2, 1'b1, 12'h002, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd4},
    '{3'd2, 1'b0, 12'h002, 32'h0,         1'b0, 32'hFFFF_FFFF, 4'd4},  // R4 unmasked
    '{3'd4, 1'b1, 12'h002, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd4},
    '{3'd4, 1'b0, 12'h002, 32'h0,         1'b0, 32'h8000_8000, 4'd4},  // R4 class 4
    '{3'd5, 1'b1, 12'h002, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd4},
    '{3'd5, 1'b0, 12'h002, 32'h0,         1'b0, 32'hF8E0_E000, 4'd4},  // R4 class 5
    '{3'd5, 1'b1, 12'h803, 32'h0000_1234, 1'b1, 32'h0, 4'd7},  // R7
    '{3'd3, 1'b1, 12'h803, 32'hABCD_0000, 1'b0, 32'h0, 4'd7},
    '{3'd3, 1'b0, 12'h803, 32'h0,         1'b0, 32'hABCD_0000, 4'd7},
    '{3'd5, 1'b0, 12'h803, 32'h0,         1'b1, 32'h0, 4'd7},
    '{3'd4, 1'b1, 12'h004, 32'h5555_AAAA, 1'b0, 32'h0, 4'd6},  // R6
    '{3'd5, 1'b0, 12'h004, 32'h0,         1'b1, 32'h0, 4'd6},
    '{3'd4, 1'b0, 12'h004, 32'h0,         1'b0, 32'h5555_AAAA, 4'd6},
    '{3'd5, 1'b1, 12'h807, 32'hCAFE_0000, 1'b0, 32'h0, 4'd5},  // R5
    '{3'd3, 1'b0, 12'h807, 32'h0,         1'b1, 32'h0, 4'd5},
    '{3'd5, 1'b0, 12'h807, 32'h0,         1'b0, 32'hCAFE_0000, 4'd5},
    '{3'd1, 1'b1, 12'h000, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd2},
    '{3'd1, 1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_0007, 4'd2},  // R2 3-bit field
    '{3'd4, 1'b1, 12'h802, 32'h0000_0001, 1'b1, 32'h0, 4'd8},  // R8
    '{3'd4, 1'b0, 12'h808, 32'h0,         1'b1, 32'h0, 4'd8},
    '{3'd0, 1'b0, 12'h801, 32'h0,         1'b1, 32'h0, 4'd1},  // R1
    '{3'd0, 1'b1, 12'h801, 32'h0000_DEAD, 1'b1, 32'h0, 4'd1},
    '{3'd1, 1'b0, 12'h801, 32'h0,         1'b0, 32'h0000_1000, 4'd9},  // R9 unchanged
    '{3'd4, 1'b1, 12'h805, 32'h0000_0077, 1'b0, 32'h0, 4'd6},
    '{3'd4, 1'b0, 12'h805, 32'h0,         1'b0, 32'h0000_0077, 4'd6},
    '{3'd6, 1'b0, 12'h801, 32'h0,         1'b1, 32'h0, 4'd1},
    '{3'd2, 1'b1, 12'h006, 32'h0000_0001, 1'b1, 32'h0, 4'd6},
    '{3'd4, 1'b0, 12'h006, 32'h0,         1'b0, 32'h0, 4'd9}   // R9 no write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] c, input logic w, input logic [11:0] cd,
                     input logic [31:0] d);
    @(negedge clk_i);
    cpu_class_i = c; wr_i = w; code_i = cd; wdata_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 rdata", rdata_o, 32'h0);
    chk("R11 exc", {31'h0, exc_o}, 32'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].cls, VEC[i].wr, VEC[i].code, VEC[i].wd);
      chk($sformatf("R%0d vec %0d exc", VEC[i].req, i), {31'h0, exc_o}, {31'h0, VEC[i].exc});
      chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), rdata_o, VEC[i].rd);
    end
    // R10 pulse width and hold while idle
    acc(3'd1, 1'b0, 12'h801, 32'h0);
    @(negedge clk_i);
    chk("R10 hold rdata", rdata_o, 32'h0000_1000);
    chk("R10 idle exc", {31'h0, exc_o}, 32'h0);
    acc(3'd1, 1'b0, 12'h802, 32'h0);
    chk("R10 exc high", {31'h0, exc_o}, 32'h1);
    @(negedge clk_i);
    chk("R10 exc one cycle", {31'h0, exc_o}, 32'h0);
    // R11 reset clears storage
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    acc(3'd4, 1'b0, 12'h002, 32'h0);
    chk("R11 cache cleared", rdata_o, 32'h0);
    acc(3'd1, 1'b0, 12'h801, 32'h0);
    chk("R11 vector cleared", rdata_o, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule